// File: doc/BRIEF.md
# Iterative SHA-1 Compression Core

This block runs the SHA-1 compression function on one 512-bit, already padded message block. One round is computed per clock, so a block takes 80 round cycles plus one cycle to fold the result into the 160-bit chaining value. Padding and length encoding are the caller's job.

A message starts with a start pulse, which compresses the block from the standard initial chaining constants. Each further block of the same message is fed with a chain pulse, which compresses from the digest currently on `hash_out`. The caller waits for `core_idle` before sending the next pulse and reads `hash_out` once `hash_ok` is high.

Control is a three-state machine:
- IDLE: waits for a pulse. On start or chain it loads the working registers and the schedule window, then goes to CRUNCH.
- CRUNCH: runs rounds 0 to 79, one per cycle. After round 79 it goes to FOLD.
- FOLD: adds the working registers to the base chaining value, raises `hash_ok`, and returns to IDLE.

Top module: `sha1_iter_core`

## Requirements
- R1: While reset is asserted, and after it is released, `core_idle` is 1, `hash_ok` is 0 and `hash_out` is all zeros. This applies to a reset that arrives in the middle of a block.
- R2: A `msg_start` pulse in IDLE compresses `msg_block` from the constants 67452301 efcdab89 98badcfe 10325476 c3d2e1f0.
  - Word 0 of the block is bits 511:480.
  - The padded one-block message "abc" gives a9993e364706816aba3e25717850c26c9cd0d89d.
- R3: A `msg_chain` pulse in IDLE compresses `msg_block` starting from the value on `hash_out`. For the 56-character two-block test message:
  - a start on block 1 gives f4286818c37b27ae0408f581846771484a566572;
  - a chain on block 2 then gives 84983e441c3bd26ebaae4aa1f95129e5e54670f1.
- R4: `core_idle` falls after the clock edge that accepts a pulse. It rises again on the 81st clock edge after that edge.
- R5: `hash_out` changes only on the edge that completes a block. It holds its old value for the whole busy period.
- R6: `hash_ok` clears on the accepting edge. It sets on the completing edge and stays high while the core is idle.
- R7: Pulses on `msg_start` or `msg_chain` while `core_idle` is low are ignored. `msg_block` is sampled only at the accepting edge, so changes to it during the busy period have no effect.
- R8: If `msg_start` and `msg_chain` are both high in IDLE, the start takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_start | input | 1 | Compress `msg_block` from the initial constants |
| msg_chain | input | 1 | Compress `msg_block` from the current digest |
| msg_block | input | 512 | Padded message block; word 0 is in the top 32 bits |
| core_idle | output | 1 | High when a pulse can be accepted |
| hash_out | output | 160 | Chaining value; the first word is in the top 32 bits |
| hash_ok | output | 1 | `hash_out` holds the result of the last accepted block |

## Verification
The hardest case to reach is a pulse that arrives in the middle of a block while the block input is also changing. A wrong design could restart, chain, or pick up the new block without changing the latency.

To reach it, the bench starts a block and, ten cycles in, raises both pulse inputs for three cycles with a different block on the input. It then checks the digest against the original block, the exact 81-edge latency, and that `hash_out` held its previous value on every cycle of the busy period.

// File: rtl/sha1c_pkg.sv
package sha1c_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 5;
    localparam int WIN_DEPTH  = 16;
    localparam int BLOCK_W    = WORD_W * WIN_DEPTH;
    localparam int HASH_W     = WORD_W * NUM_WORDS;
    localparam int NUM_ROUNDS = 80;
    localparam int PHASE_LEN  = 20;
    localparam int RND_W      = $clog2(NUM_ROUNDS);

    typedef logic [WORD_W-1:0] word_t;
    // Index 4 holds a / H0 (most significant), index 0 holds e / H4.
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] chain_t;

    localparam chain_t IV_VALUE = 160'h67452301efcdab8998badcfe10325476c3d2e1f0;

    typedef enum logic [1:0] {ST_IDLE, ST_CRUNCH, ST_FOLD} phase_e;

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t round_const(input logic [RND_W-1:0] t);
        if (int'(t) < PHASE_LEN)            return 32'h5a827999;
        else if (int'(t) < 2 * PHASE_LEN)   return 32'h6ed9eba1;
        else if (int'(t) < 3 * PHASE_LEN)   return 32'h8f1bbcdc;
        else                                return 32'hca62c1d6;
    endfunction

    function automatic word_t mix_fn(input logic [RND_W-1:0] t,
                                     input word_t b, input word_t c, input word_t d);
        if (int'(t) < PHASE_LEN)
            return (b & c) | (~b & d);
        else if (int'(t) >= 2 * PHASE_LEN && int'(t) < 3 * PHASE_LEN)
            return (b & c) | (b & d) | (c & d);
        else
            return b ^ c ^ d;
    endfunction
endpackage

// File: rtl/sha1c_sched.sv
module sha1c_sched
    import sha1c_pkg::*;
#(
    parameter int DEPTH = WIN_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [DEPTH*WORD_W-1:0]   block,
    output word_t                     w_now
);
    localparam int TAP_3  = DEPTH - 3;
    localparam int TAP_8  = DEPTH - 8;
    localparam int TAP_14 = DEPTH - 14;

    logic [DEPTH-1:0][WORD_W-1:0] win_q;
    word_t fresh;

    // Slot 0 is the word used this round; slot DEPTH-1 receives W[t+16].
    assign fresh = rotl(win_q[TAP_3] ^ win_q[TAP_8] ^ win_q[TAP_14] ^ win_q[0], 1);
    assign w_now = win_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (load) begin
            for (int i = 0; i < DEPTH; i++)
                win_q[i] <= block[DEPTH*WORD_W-1-WORD_W*i -: WORD_W];
        end else if (step) begin
            for (int i = 0; i < DEPTH-1; i++)
                win_q[i] <= win_q[i+1];
            win_q[DEPTH-1] <= fresh;
        end
    end
endmodule

// File: rtl/sha1c_round.sv
module sha1c_round
    import sha1c_pkg::*;
(
    input  chain_t            st,
    input  word_t             w,
    input  logic [RND_W-1:0]  idx,
    output chain_t            nx
);
    word_t a, b, c, d, e, temp;

    assign a = st[4];
    assign b = st[3];
    assign c = st[2];
    assign d = st[1];
    assign e = st[0];

    assign temp = rotl(a, 5) + mix_fn(idx, b, c, d) + e + round_const(idx) + w;
    assign nx   = {temp, a, rotl(b, 30), c, d};
endmodule

// File: rtl/sha1c_ctrl.sv
module sha1c_ctrl
    import sha1c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              chain_req,
    output logic [RND_W-1:0]  idx,
    output logic              load,
    output logic              use_iv,
    output logic              step,
    output logic              fold,
    output logic              idle,
    output logic              done
);
    localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS - 1);

    phase_e st_q, st_d;
    logic   accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (accept)      st_d = ST_CRUNCH;
            ST_CRUNCH: if (idx == LAST) st_d = ST_FOLD;
            ST_FOLD:                    st_d = ST_IDLE;
            default:                    st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle   = (st_q == ST_IDLE);
        accept = idle && (start_req || chain_req);
        load   = accept;
        use_iv = start_req;      // start outranks chain (R8)
        step   = (st_q == ST_CRUNCH);
        fold   = (st_q == ST_FOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     idx <= '0;
        else if (accept)                idx <= '0;
        else if (step && idx != LAST)   idx <= idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      done <= 1'b0;
        else if (accept) done <= 1'b0;
        else if (fold)   done <= 1'b1;
    end

    a_r4_ctr_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);
    a_r4_fold_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FOLD) |=> (st_q == ST_IDLE));
    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CRUNCH && idx != LAST) |=> (st_q == ST_CRUNCH && idx == $past(idx) + 1'b1));
    a_r6_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done && st_q == ST_CRUNCH && idx == '0));
endmodule

// File: rtl/sha1_iter_core.sv
module sha1_iter_core
    import sha1c_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_start,
    input  logic                msg_chain,
    input  logic [BLOCK_W-1:0]  msg_block,
    output logic                core_idle,
    output logic [HASH_W-1:0]   hash_out,
    output logic                hash_ok
);
    logic [RND_W-1:0] idx;
    logic   load, use_iv, step, fold;
    logic   iv_q;
    word_t  w_now;
    chain_t h_q, wk_q, wk_nx, base, fold_sum;

    sha1c_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(msg_start), .chain_req(msg_chain),
        .idx(idx), .load(load), .use_iv(use_iv), .step(step), .fold(fold),
        .idle(core_idle), .done(hash_ok)
    );

    sha1c_sched #(.DEPTH(WIN_DEPTH)) u_sched (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .block(msg_block), .w_now(w_now)
    );

    sha1c_round u_round (.st(wk_q), .w(w_now), .idx(idx), .nx(wk_nx));

    // Base is chosen at fold time so hash_out stays untouched while busy.
    assign base = iv_q ? IV_VALUE : h_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_fold
        assign fold_sum[g] = base[g] + wk_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q  <= '0;
            wk_q <= '0;
            iv_q <= 1'b0;
        end else if (load) begin
            wk_q <= use_iv ? IV_VALUE : h_q;
            iv_q <= use_iv;
        end else if (step) begin
            wk_q <= wk_nx;
        end else if (fold) begin
            h_q <= fold_sum;
        end
    end

    assign hash_out = h_q;

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fold |=> $stable(hash_out));
    a_r6_ok_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hash_ok) |-> $past(fold));
    a_r4_idle_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
        fold |=> (core_idle && hash_ok));
endmodule

// File: tb/sha1_iter_core_bench.sv
module sha1_iter_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 81;

    localparam logic [511:0] BLK_ABC = {32'h61626380, 416'h0, 64'h18};
    localparam logic [511:0] BLK_M1  = {"abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq",
                                        64'h8000000000000000};
    localparam logic [511:0] BLK_M2  = {448'h0, 64'h1c0};
    localparam logic [159:0] H_ABC   = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
    localparam logic [159:0] H_M1    = 160'hf4286818c37b27ae0408f581846771484a566572;
    localparam logic [159:0] H_M2    = 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1;

    localparam logic [511:0] VEC_BLK   [3] = '{BLK_ABC, BLK_M1, BLK_M2};
    localparam logic [159:0] VEC_HASH  [3] = '{H_ABC, H_M1, H_M2};
    localparam bit           VEC_START [3] = '{1'b1, 1'b1, 1'b0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         msg_start = 1'b0;
    logic         msg_chain = 1'b0;
    logic [511:0] msg_block = '0;
    logic         core_idle;
    logic [159:0] hash_out;
    logic         hash_ok;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    sha1_iter_core u_sha1_iter_core (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_chain(msg_chain),
        .msg_block(msg_block), .core_idle(core_idle), .hash_out(hash_out), .hash_ok(hash_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic s, input logic c, input logic [511:0] b);
        @(negedge clk);
        msg_start = s;
        msg_chain = c;
        msg_block = b;
        @(negedge clk);
        msg_start = 1'b0;
        msg_chain = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!core_idle && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=idle");
            report();
            $finish;
        end
    end

    initial begin
        int  n;
        bit  stable_ok, quiet_ok;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 160'(core_idle), 160'd1);
        check("R1 ok after reset", 160'(hash_ok), 160'd0);
        check("R1 hash after reset", hash_out, 160'd0);

        // R2/R3/R4/R6: vector table
        for (int i = 0; i < 3; i++) begin
            send(VEC_START[i], !VEC_START[i], VEC_BLK[i]);
            check("R4 busy after accept", 160'(core_idle), 160'd0);
            wait_idle(n);
            check("R4 latency", 160'(n), 160'(LATENCY));
            check(VEC_START[i] ? "R2 start digest" : "R3 chain digest", hash_out, VEC_HASH[i]);
            check("R6 ok at completion", 160'(hash_ok), 160'd1);
        end

        // R5/R6/R7: pulses and block changes while busy
        send(1'b1, 1'b0, BLK_ABC);
        stable_ok = 1'b1;
        quiet_ok = 1'b1;
        n = 0;
        while (!core_idle && n < 500) begin
            if (hash_out !== H_M2) stable_ok = 1'b0;
            if (hash_ok) quiet_ok = 1'b0;
            if (n == 10) begin
                msg_start = 1'b1;
                msg_chain = 1'b1;
                msg_block = BLK_M2;
            end
            if (n == 13) begin
                msg_start = 1'b0;
                msg_chain = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        check("R4 latency with busy pulses", 160'(n), 160'(LATENCY));
        check("R5 hash held while busy", 160'(stable_ok), 160'd1);
        check("R6 ok low while busy", 160'(quiet_ok), 160'd1);
        check("R7 busy pulses ignored", hash_out, H_ABC);
        repeat (5) @(negedge clk);
        check("R6 ok held while idle", 160'(hash_ok), 160'd1);
        check("R7 hash after ignored pulses", hash_out, H_ABC);
        check("R7 idle after ignored pulses", 160'(core_idle), 160'd1);

        // R8: both pulses together, start wins
        send(1'b1, 1'b1, BLK_ABC);
        wait_idle(n);
        check("R8 start priority", hash_out, H_ABC);

        // R1: reset in mid-block, then a fresh start
        send(1'b1, 1'b0, BLK_M1);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 idle in mid-block reset", 160'(core_idle), 160'd1);
        check("R1 ok in mid-block reset", 160'(hash_ok), 160'd0);
        check("R1 hash in mid-block reset", hash_out, 160'd0);
        rst_n = 1'b1;
        send(1'b1, 1'b0, BLK_ABC);
        wait_idle(n);
        check("R2 start after reset", hash_out, H_ABC);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule